// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block watches a set of external signal lines and turns selected transitions on them into interrupt requests, event pulses and low-power-domain wakeup signals. Every line passes through a two-flop synchronizer and an edge detector whose rising and falling sensitivity are enabled separately. A detected edge, or a software trigger write, sets a sticky per-line pending flag. The interrupt output of a line is that flag gated by the line's interrupt mask. An independent event mask turns the same trigger into a single-cycle pulse that does not depend on the flag.

The lowest 16 lines take their input from a port multiplexer. A 4-bit field per line chooses which 16-pin port drives it. The remaining lines come straight from dedicated inputs. Each line also drives a wakeup signal for a low-power domain. In the default mode this signal drops by itself a fixed number of cycles after the trigger. In the alternative mode it stays high until one of four hardware clear inputs, picked by a 2-bit field, is asserted.

Software reaches the block through a plain register port: a write strobe with address and data, and a read path that always shows the register at the current address.

Top module: `xint_ctrl`

## Requirements
- R1: After reset every register reads 0, and every `irq`, `evt` and `wake` bit is 0.
- R2: With the line's bit set in the rising-enable register (address 0), a 0-to-1 change on the line input sets the line's pending bit (address 4) on the third rising clock edge after the change. A 1-to-0 change on a line that has only rising enabled sets nothing.
- R3: The falling-enable register (address 1) does the same for 1-to-0 changes. With both enables set a line triggers on either change. With neither set it never triggers on its input.
- R4: `irq[n]` equals pending bit n AND bit n of the interrupt-mask register (address 2). A mask change takes effect in the cycle after the write.
- R5: When bit n of the event-mask register (address 3) is set, `evt[n]` is high for exactly one cycle after each trigger of line n, even when the pending bit is already set. When that mask bit is clear, no pulse appears.
- R6: Writing the pending register (address 4) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: Writing 1 to bit n of the software-trigger register (address 5) sets pending bit n at that clock edge, as an edge would. This register always reads 0.
- R8: When a detected edge and a clearing write hit the same line in the same cycle, the pending bit ends up set.
- R9: Line n, for n from 0 to 15, takes pin n of the port chosen by a 4-bit field in register 9 + n/4 at bits [4*(n mod 4)+3 : 4*(n mod 4)]. A field value of NUM_PORTS or more feeds a constant 0. Lines 16 and up take `aux_lines[n-16]`.
- R10: With bit n of the wake-mode register (address 6) at 0, `wake[n]` rises at the trigger edge and stays high for exactly WAKE_DELAY cycles (default 4). A new trigger restarts the count.
- R11: With that wake-mode bit at 1, `wake[n]` stays high until `clr_src[k]` is sampled high at a clock edge, where k is line n's 2-bit field (00→0, 01→1, 10→2, 11→3). The field sits in register 7 for lines 0–15 and register 8 for lines 16 and up, at bits [2*(n mod 16)+1 : 2*(n mod 16)]. The other clear inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (write and read) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| port_pins | input | NUM_PORTS*16 | Port pins, port p pin i at bit 16*p+i |
| aux_lines | input | NUM_LINES-16 | Direct inputs for lines 16 and up |
| clr_src | input | 4 | Hardware wakeup clear inputs |
| irq | output | NUM_LINES | Per-line interrupt request |
| evt | output | NUM_LINES | Per-line single-cycle event pulse |
| wake | output | NUM_LINES | Per-line low-power-domain wakeup |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges have passed, so that every `$past` term refers to defined state. They also assume that `clr_src` and the register port are synchronous to `clk`. The bench drives all inputs, including pins and clear sources, on the falling clock edge, so every input is stable around the rising edge. The pins are held steady for many cycles between changes, which means a line never sees two edges in consecutive cycles.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int REG_W      = 32;
    localparam int MUX_LINES  = 16;
    localparam int PSEL_W     = 4;
    localparam int CSEL_W     = 2;
    localparam int NUM_CLR    = 4;

    typedef enum logic [3:0] {
        RG_RISE    = 4'd0,
        RG_FALL    = 4'd1,
        RG_IMASK   = 4'd2,
        RG_EMASK   = 4'd3,
        RG_PEND    = 4'd4,
        RG_SWTRIG  = 4'd5,
        RG_WMODE   = 4'd6,
        RG_CSEL_LO = 4'd7,
        RG_CSEL_HI = 4'd8,
        RG_PSEL0   = 4'd9,
        RG_PSEL1   = 4'd10,
        RG_PSEL2   = 4'd11,
        RG_PSEL3   = 4'd12
    } xint_reg_e;

    typedef struct packed {
        logic       en;
        xint_reg_e  addr;
        logic [REG_W-1:0] data;
    } xint_wr_t;

    function automatic logic wr_hits(xint_wr_t w, xint_reg_e a);
        return w.en && (w.addr == a);
    endfunction

endpackage

// File: rtl/xint_port_mux.sv
module xint_port_mux
    import xint_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [NUM_PORTS*MUX_LINES-1:0] pins,
    input  logic [MUX_LINES*PSEL_W-1:0]    sel,
    output logic [MUX_LINES-1:0]           mux_out
);

    for (genvar n = 0; n < MUX_LINES; n++) begin : g_line
        logic [PSEL_W-1:0] fsel;
        assign fsel = sel[n*PSEL_W +: PSEL_W];
        always_comb begin
            mux_out[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (fsel == PSEL_W'(p)) mux_out[n] = pins[p*MUX_LINES + n];
            end
        end
    end

endmodule

// File: rtl/xint_edge_det.sv
module xint_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_in,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] hit
);

    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= line_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign hit = (s2_q & ~s3_q & rise_en) | (~s2_q & s3_q & fall_en);

endmodule

// File: rtl/xint_wake_unit.sv
module xint_wake_unit
    import xint_pkg::*;
#(
    parameter int WAKE_DELAY = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic               mode,
    input  logic [CSEL_W-1:0]  csel,
    input  logic [NUM_CLR-1:0] clr_src,
    output logic               wake
);

    localparam int CW = $clog2(WAKE_DELAY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake  <= 1'b0;
            cnt_q <= '0;
        end else if (trig) begin
            wake  <= 1'b1;
            cnt_q <= CW'(WAKE_DELAY);
        end else if (wake) begin
            if (mode) begin
                if (clr_src[csel]) wake <= 1'b0;
            end else if (cnt_q <= CW'(1)) begin
                wake <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_PORTS  = 4,
    parameter int WAKE_DELAY = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_wr,
    input  logic [3:0]                    reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_PORTS*16-1:0]       port_pins,
    input  logic [NUM_LINES-17:0]         aux_lines,
    input  logic [3:0]                    clr_src,
    output logic [NUM_LINES-1:0]          irq,
    output logic [NUM_LINES-1:0]          evt,
    output logic [NUM_LINES-1:0]          wake
);

    localparam int NL      = NUM_LINES;
    localparam int HI_BITS = CSEL_W * (NL - MUX_LINES);
    localparam int PS_BITS = MUX_LINES * PSEL_W;

    xint_wr_t wq;
    assign wq = '{en: reg_wr, addr: xint_reg_e'(reg_addr), data: reg_wdata};

    logic [NL-1:0]          rise_q, fall_q, imask_q, emask_q, wmode_q, pend_q;
    logic [CSEL_W*NL-1:0]   csel_q;
    logic [PS_BITS-1:0]     psel_q;
    logic [NL-1:0]          evt_q;

    logic [MUX_LINES-1:0]   mux_lines;
    logic [NL-1:0]          line_in, hit, sw_set, w1c, trig_vec;

    xint_port_mux #(.NUM_PORTS(NUM_PORTS)) u_mux (
        .pins    (port_pins),
        .sel     (psel_q),
        .mux_out (mux_lines)
    );

    assign line_in = {aux_lines, mux_lines};

    xint_edge_det #(.W(NL)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .rise_en (rise_q),
        .fall_en (fall_q),
        .hit     (hit)
    );

    assign sw_set   = wr_hits(wq, RG_SWTRIG) ? wq.data[NL-1:0] : '0;
    assign w1c      = wr_hits(wq, RG_PEND)   ? wq.data[NL-1:0] : '0;
    assign trig_vec = hit | sw_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q  <= '0;
            fall_q  <= '0;
            imask_q <= '0;
            emask_q <= '0;
            wmode_q <= '0;
            csel_q  <= '0;
            psel_q  <= '0;
            pend_q  <= '0;
            evt_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~w1c) | trig_vec;
            evt_q  <= trig_vec & emask_q;
            if (wq.en) begin
                case (wq.addr)
                    RG_RISE:    rise_q  <= wq.data[NL-1:0];
                    RG_FALL:    fall_q  <= wq.data[NL-1:0];
                    RG_IMASK:   imask_q <= wq.data[NL-1:0];
                    RG_EMASK:   emask_q <= wq.data[NL-1:0];
                    RG_WMODE:   wmode_q <= wq.data[NL-1:0];
                    RG_CSEL_LO: csel_q[31:0] <= wq.data;
                    RG_CSEL_HI: csel_q[CSEL_W*NL-1:32] <= wq.data[HI_BITS-1:0];
                    RG_PSEL0:   psel_q[15:0]  <= wq.data[15:0];
                    RG_PSEL1:   psel_q[31:16] <= wq.data[15:0];
                    RG_PSEL2:   psel_q[47:32] <= wq.data[15:0];
                    RG_PSEL3:   psel_q[63:48] <= wq.data[15:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (xint_reg_e'(reg_addr))
            RG_RISE:    reg_rdata = 32'(rise_q);
            RG_FALL:    reg_rdata = 32'(fall_q);
            RG_IMASK:   reg_rdata = 32'(imask_q);
            RG_EMASK:   reg_rdata = 32'(emask_q);
            RG_PEND:    reg_rdata = 32'(pend_q);
            RG_WMODE:   reg_rdata = 32'(wmode_q);
            RG_CSEL_LO: reg_rdata = csel_q[31:0];
            RG_CSEL_HI: reg_rdata = 32'(csel_q[CSEL_W*NL-1:32]);
            RG_PSEL0:   reg_rdata = {16'h0, psel_q[15:0]};
            RG_PSEL1:   reg_rdata = {16'h0, psel_q[31:16]};
            RG_PSEL2:   reg_rdata = {16'h0, psel_q[47:32]};
            RG_PSEL3:   reg_rdata = {16'h0, psel_q[63:48]};
            default:    reg_rdata = 32'h0;
        endcase
    end

    for (genvar n = 0; n < NL; n++) begin : g_wake
        xint_wake_unit #(.WAKE_DELAY(WAKE_DELAY)) u_wake (
            .clk     (clk),
            .rst     (rst),
            .trig    (trig_vec[n]),
            .mode    (wmode_q[n]),
            .csel    (csel_q[n*CSEL_W +: CSEL_W]),
            .clr_src (clr_src),
            .wake    (wake[n])
        );
    end

    assign irq = pend_q & imask_q;
    assign evt = evt_q;

endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [3:0]           reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [NUM_LINES-1:0] trig_vec,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] emask_q,
    input logic [NUM_LINES-1:0] evt,
    input logic [NUM_LINES-1:0] wake
);

    logic pend_wr, sw_wr;
    assign pend_wr = reg_wr && (reg_addr == RG_PEND);
    assign sw_wr   = reg_wr && (reg_addr == RG_SWTRIG);

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(pend_wr) |-> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(pend_wr) |-> ((pend_q & $past(reg_wdata[NUM_LINES-1:0]) & ~$past(trig_vec)) == '0)); // R6

    AST_SW_SETS: assert property (@(posedge clk) disable iff (rst)
        $past(sw_wr) |-> ((pend_q & $past(reg_wdata[NUM_LINES-1:0])) == $past(reg_wdata[NUM_LINES-1:0]))); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & $past(trig_vec)) == $past(trig_vec))); // R8

    AST_EVT_MASKED: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~$past(emask_q)) == '0)); // R5

    AST_WAKE_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
        ((wake & $past(trig_vec)) == $past(trig_vec))); // R10

endmodule

bind xint_ctrl xint_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .trig_vec  (trig_vec),
    .pend_q    (pend_q),
    .emask_q   (emask_q),
    .evt       (evt),
    .wake      (wake)
);

// File: tb/tb_xint_ctrl.sv
module tb_xint_ctrl;

    localparam int NL = 32;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP*16-1:0] port_pins = '0;
    logic [NL-17:0]   aux_lines = '0;
    logic [3:0]    clr_src = '0;
    logic [NL-1:0] irq, evt, wake;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    xint_ctrl #(.NUM_LINES(NL), .NUM_PORTS(NP), .WAKE_DELAY(4)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_pins(port_pins),
        .aux_lines(aux_lines), .clr_src(clr_src), .irq(irq), .evt(evt), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 13; a++) begin
            rd(4'(a), d);
            chk($sformatf("R1 reg %0d", a), d, 32'h0);
        end
        chk("R1 irq", irq, '0);
        chk("R1 evt", evt, '0);
        chk("R1 wake", wake, '0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(4'd0, 32'h0000_0008);
        wr(4'd2, 32'h0000_0008);
        @(negedge clk); port_pins[3] = 1'b1;
        settle(2);
        rd(4'd4, d);
        chk("R2 not yet after two edges", d & 32'h8, 32'h0);
        settle(1);
        chk("R2 irq after rise", 32'(irq[3]), 32'h1);
        wr(4'd4, 32'h8);
        port_pins[3] = 1'b0;
        settle(5);
        rd(4'd4, d);
        chk("R2 fall ignored when only rise on", d & 32'h8, 32'h0);
    endtask

    task automatic t_fall_both();
        logic [31:0] d;
        wr(4'd1, 32'h0000_0060);
        wr(4'd0, 32'h0000_0048);
        @(negedge clk); port_pins[5] = 1'b1; port_pins[6] = 1'b1; port_pins[7] = 1'b1;
        settle(4);
        rd(4'd4, d);
        chk("R3 rise on fall-only/both/neither", d & 32'hE0, 32'h40);
        wr(4'd4, 32'hFF);
        port_pins[5] = 1'b0; port_pins[6] = 1'b0; port_pins[7] = 1'b0;
        settle(4);
        rd(4'd4, d);
        chk("R3 fall on fall-only/both/neither", d & 32'hE0, 32'h60);
        wr(4'd4, 32'hFF);
    endtask

    task automatic t_mask();
        wr(4'd2, 32'h0);
        wr(4'd5, 32'h0000_0400);
        chk("R4 irq masked", 32'(irq[10]), 32'h0);
        wr(4'd2, 32'h0000_0400);
        chk("R4 irq after mask set", irq, 32'h0000_0400);
        wr(4'd4, 32'h0000_0400);
        chk("R4 irq after clear", irq, 32'h0);
        wr(4'd2, 32'h0);
    endtask

    task automatic t_event();
        wr(4'd3, 32'h0000_0004);
        wr(4'd5, 32'h0000_0004);
        chk("R5 evt pulse", evt, 32'h4);
        @(negedge clk);
        chk("R5 evt one cycle", evt, 32'h0);
        wr(4'd5, 32'h0000_0004);
        chk("R5 evt with pending already set", evt, 32'h4);
        wr(4'd3, 32'h0);
        wr(4'd5, 32'h0000_0004);
        chk("R5 no evt when unmasked", evt, 32'h0);
        wr(4'd4, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c_sw();
        logic [31:0] d;
        wr(4'd5, 32'h8000_0016);
        rd(4'd4, d);
        chk("R7 sw trigger sets pending", d, 32'h8000_0016);
        rd(4'd5, d);
        chk("R7 sw register reads zero", d, 32'h0);
        wr(4'd4, 32'h0);
        rd(4'd4, d);
        chk("R6 zero write no effect", d, 32'h8000_0016);
        wr(4'd4, 32'h0000_0004);
        rd(4'd4, d);
        chk("R6 only written bit cleared", d, 32'h8000_0012);
        wr(4'd4, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        wr(4'd0, 32'h0010_0000);
        wr(4'd5, 32'h0010_0000);
        @(negedge clk); aux_lines[4] = 1'b1;
        @(negedge clk);
        wr(4'd4, 32'h0010_0000);
        rd(4'd4, d);
        chk("R8 edge beats clear", d & 32'h0010_0000, 32'h0010_0000);
        wr(4'd4, 32'h0010_0000);
        rd(4'd4, d);
        chk("R8 plain clear", d & 32'h0010_0000, 32'h0);
    endtask

    task automatic t_mux();
        logic [31:0] d;
        wr(4'd11, 32'h0000_0020);
        rd(4'd11, d);
        chk("R9 select readback", d, 32'h20);
        wr(4'd0, 32'h0000_0200);
        wr(4'd1, 32'h0000_0200);
        @(negedge clk); port_pins[9] = 1'b1;
        settle(4);
        rd(4'd4, d);
        chk("R9 unselected port ignored", d & 32'h200, 32'h0);
        port_pins[2*16 + 9] = 1'b1;
        settle(4);
        rd(4'd4, d);
        chk("R9 selected port edge", d & 32'h200, 32'h200);
        wr(4'd4, 32'h200);
        wr(4'd11, 32'h0000_0070);
        settle(3);
        rd(4'd4, d);
        chk("R9 out-of-range select reads 0", d & 32'h200, 32'h200);
        wr(4'd4, 32'h200);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h0);
    endtask

    task automatic t_wake_delay();
        wr(4'd5, 32'h0000_0002);
        for (int i = 0; i < 4; i++) begin
            chk($sformatf("R10 wake high cycle %0d", i), 32'(wake[1]), 32'h1);
            @(negedge clk);
        end
        chk("R10 wake low after delay", 32'(wake[1]), 32'h0);
        wr(4'd4, 32'hFFFF_FFFF);
    endtask

    task automatic t_wake_src();
        logic [31:0] d;
        wr(4'd6, 32'h0004_0020);
        wr(4'd7, 32'h0000_0C00);
        wr(4'd8, 32'h0000_0020);
        rd(4'd8, d);
        chk("R11 high field readback", d, 32'h20);
        wr(4'd5, 32'h0004_0000);
        settle(6);
        chk("R11 wake held past delay", 32'(wake[18]), 32'h1);
        clr_src = 4'b1011;
        @(negedge clk);
        chk("R11 other sources ignored", 32'(wake[18]), 32'h1);
        clr_src = 4'b0100;
        @(negedge clk);
        chk("R11 selected source 10 clears", 32'(wake[18]), 32'h0);
        clr_src = 4'b0000;
        wr(4'd5, 32'h0000_0020);
        clr_src = 4'b0111;
        @(negedge clk);
        chk("R11 low-reg line ignores others", 32'(wake[5]), 32'h1);
        clr_src = 4'b1000;
        @(negedge clk);
        chk("R11 selected source 11 clears", 32'(wake[5]), 32'h0);
        clr_src = 4'b0000;
        wr(4'd4, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: R1..R11 run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        settle(4);
        rst = 1'b0;
        settle(1);
        t_reset();
        t_rise();
        t_fall_both();
        t_mask();
        t_event();
        t_w1c_sw();
        t_set_wins();
        t_mux();
        t_wake_delay();
        t_wake_src();
        settle(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule